// File: doc/BRIEF.md
# Write-Back Cache Line Sequencer

This block is the control path of a small direct-mapped write-back cache with 16-byte lines. It sits between a CPU request port and a 32-bit external memory port. Every cacheable request is checked against a tag store. A hit is served from the line array and never touches memory. A miss refills the whole line with four longword reads. If the displaced line is valid and dirty, it is first parked in a line-wide buffer and written out as a four-beat burst after the new line is installed and any write data is merged in.

Requests marked non-cacheable skip the tag store. They make one memory cycle at the request's own address and width. An uncached instruction fetch picks its width from the address: longword on a 4n boundary and 16-bit on 4n+2. The CPU port is a valid/ready pair and accepts one request at a time. Ready stays low from acceptance until the final write-back beat has been taken by memory.

Top module: `wb_line_seq`

## Requirements
- R1: A line fill is four 32-bit read cycles with all four byte enables set. They target line offsets 0, 4, 8 and 12 in that order, one beat per cycle in which `mem_ready` is high.
- R2: A cacheable read miss of any size, including an instruction fetch at a 4n+2 address, performs a full line fill. The response arrives in the cycle after the fourth beat is taken and carries the longword containing the requested address.
- R3: A cacheable read hit makes no memory cycle. Its response is valid in the second cycle after acceptance and carries the 32-bit aligned word containing the address.
- R4: A cacheable write hit makes no memory cycle. It updates only the bytes selected by its byte enables in the cached line and marks the line dirty.
- R5: A cacheable write miss fills the line and then merges the write data into it. Write data is lane-aligned: byte lane b is bits 8b+7..8b and maps to address offset b within the longword.
- R6: On any cacheable miss whose victim line is both valid and dirty, the victim is written back after the fill. This is four 32-bit writes at the victim's own line address, offsets 0, 4, 8 and 12 in order. A clean or invalid victim produces no write.
- R7: A non-cacheable data access makes exactly one memory cycle at the request address. Size code 0 is a byte with enable 1 shifted left by address bits 1..0. Size code 1 is a half-word with enables 4'b0011, or 4'b1100 when address bit 1 is set. Size code 2 is a longword with enables 4'b1111.
- R8: A non-cacheable instruction fetch is a 32-bit access (enables 4'b1111) when address bit 1 is clear, and a 16-bit access (enables 4'b1100) when it is set. The size input is ignored.
- R9: A non-cacheable read returns the memory word on the response in the cycle after the memory cycle is taken.
- R10: `req_ready` is high only when the block is idle. After acceptance no further request is taken until every fill and write-back beat of the current request has completed. The response is a single-cycle pulse.
- R11: After reset every line is invalid, `req_ready` is high, and `mem_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_write | input | 1 | 1 for a store, 0 for a load or fetch |
| req_cached | input | 1 | 1 when the address lies in a cacheable region |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_size | input | 2 | 0 byte, 1 half-word, 2 longword |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Lane-aligned store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Longword holding the requested bytes |
| mem_valid | output | 1 | Memory cycle requested |
| mem_ready | input | 1 | Memory takes the cycle this clock |
| mem_write | output | 1 | Memory cycle is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid while the cycle is taken |

## Verification
With memory always ready, the response to an accepted request comes a fixed number of rising edges after the acceptance edge. A hit takes two edges: acceptance, then the registered lookup. A non-cacheable access takes three, one more for its single memory beat. A miss takes six, four more for the fill beats. A dirty victim adds four more edges before ready returns. The bench drives on falling edges, counts falling edges until `rsp_valid` is seen, and compares that count with these figures. It then waits for ready and compares the logged memory cycles, in order, with the addresses, enables and data predicted from its own tag and memory model. When memory stalls are injected, only ordering and data are compared, not latency.

// File: rtl/wbls_pkg.sv
package wbls_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LINE_WORDS = 4;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_BYTES-1:0] lanes_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOOKUP = 3'd1,
        S_FILL   = 3'd2,
        S_WBACK  = 3'd3,
        S_UNC    = 3'd4
    } seq_st_t;
endpackage

// File: rtl/wbls_lane.sv
module wbls_lane
    import wbls_pkg::*;
(
    input  logic [1:0] addr_lo_i,
    input  logic [1:0] size_i,
    input  logic       fetch_i,
    output lanes_t     be_o
);
    always_comb begin
        if (fetch_i) begin
            be_o = addr_lo_i[1] ? 4'b1100 : 4'b1111;
        end else begin
            case (size_i)
                SZ_BYTE: be_o = 4'b0001 << addr_lo_i;
                SZ_HALF: be_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
                default: be_o = 4'b1111;
            endcase
        end
    end
endmodule

// File: rtl/wbls_merge.sv
module wbls_merge
    import wbls_pkg::*;
(
    input  line_t              line_i,
    input  word_t              word_i,
    input  lanes_t             be_i,
    input  logic [WSEL_W-1:0]  sel_i,
    output line_t              line_o,
    output word_t              word_o
);
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            assign line_o[w*WORD_W + b*8 +: 8] =
                (sel_i == WSEL_W'(w) && be_i[b]) ? word_i[b*8 +: 8]
                                                 : line_i[w*WORD_W + b*8 +: 8];
        end
    end

    assign word_o = line_i[int'(sel_i)*WORD_W +: WORD_W];
endmodule

// File: rtl/wbls_store.sv
module wbls_store
    import wbls_pkg::*;
#(
    parameter  int SETS  = 4,
    parameter  int TAG_W = 6,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty,
    input  line_t            wr_line
);
    logic [SETS-1:0]  valid_d, valid_q;
    logic [SETS-1:0]  dirty_d, dirty_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    line_t            data_q [SETS];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[wr_idx] = 1'b1;
            dirty_d[wr_idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/wb_line_seq.sv
module wb_line_seq
    import wbls_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_cached,
    input  logic              req_fetch,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam int OFF_W   = $clog2(LINE_WORDS * WORD_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int FB_W    = (LINE_WORDS - 1) * WORD_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    typedef struct packed {
        seq_st_t             st;
        logic [WSEL_W-1:0]   beat;
        logic                wr;
        logic                cached;
        logic                fetch;
        logic [1:0]          size;
        logic [ADDR_W-1:0]   addr;
        word_t               wdata;
        logic [FB_W-1:0]     fb;
        line_t               vbuf;
        logic [TAG_W-1:0]    vtag;
        logic                wb_pend;
        logic                rsp_v;
        word_t               rsp_d;
    } seq_t;

    seq_t q, d;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] woff;
    logic              hit;
    lanes_t            lane_be, merge_be;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    line_t             rd_line, hit_line, fill_line, fill_merged;
    word_t             hit_word, fill_word;
    logic              st_we, st_dirty;
    line_t             st_line;

    assign idx       = q.addr[OFF_W +: IDX_W];
    assign tag       = q.addr[ADDR_W-1 -: TAG_W];
    assign woff      = q.addr[2 +: WSEL_W];
    assign hit       = rd_valid && (rd_tag == tag);
    assign merge_be  = q.wr ? lane_be : '0;
    assign fill_line = {mem_rdata, q.fb};

    wbls_lane u_lane (
        .addr_lo_i (q.addr[1:0]),
        .size_i    (q.size),
        .fetch_i   (q.fetch),
        .be_o      (lane_be)
    );

    wbls_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    (st_we),
        .wr_idx   (idx),
        .wr_tag   (tag),
        .wr_dirty (st_dirty),
        .wr_line  (st_line)
    );

    wbls_merge u_hit_merge (
        .line_i (rd_line),
        .word_i (q.wdata),
        .be_i   (merge_be),
        .sel_i  (woff),
        .line_o (hit_line),
        .word_o (hit_word)
    );

    wbls_merge u_fill_merge (
        .line_i (fill_line),
        .word_i (q.wdata),
        .be_i   (merge_be),
        .sel_i  (woff),
        .line_o (fill_merged),
        .word_o (fill_word)
    );

    always_comb begin
        d         = q;
        d.rsp_v   = 1'b0;
        req_ready = (q.st == S_IDLE);
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_be    = '0;
        mem_wdata = '0;
        st_we     = 1'b0;
        st_dirty  = 1'b0;
        st_line   = hit_line;

        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st     = S_LOOKUP;
                    d.wr     = req_write;
                    d.cached = req_cached;
                    d.fetch  = req_fetch;
                    d.size   = req_size;
                    d.addr   = req_addr;
                    d.wdata  = req_wdata;
                end
            end
            S_LOOKUP: begin
                if (!q.cached) begin
                    d.st = S_UNC;
                end else if (hit) begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = hit_word;
                    d.st    = S_IDLE;
                    if (q.wr) begin
                        st_we    = 1'b1;
                        st_dirty = 1'b1;
                        st_line  = hit_line;
                    end
                end else begin
                    d.wb_pend = rd_valid && rd_dirty;
                    d.vbuf    = rd_line;
                    d.vtag    = rd_tag;
                    d.beat    = '0;
                    d.st      = S_FILL;
                end
            end
            S_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {tag, idx, q.beat, 2'b00};
                mem_be    = '1;
                if (mem_ready) begin
                    d.beat = q.beat + 1'b1;
                    if (q.beat != LAST_BEAT) begin
                        d.fb[int'(q.beat)*WORD_W +: WORD_W] = mem_rdata;
                    end else begin
                        st_we    = 1'b1;
                        st_dirty = q.wr;
                        st_line  = fill_merged;
                        d.rsp_v  = 1'b1;
                        d.rsp_d  = fill_word;
                        d.beat   = '0;
                        d.st     = q.wb_pend ? S_WBACK : S_IDLE;
                    end
                end
            end
            S_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {q.vtag, idx, q.beat, 2'b00};
                mem_be    = '1;
                mem_wdata = q.vbuf[int'(q.beat)*WORD_W +: WORD_W];
                if (mem_ready) begin
                    d.beat = q.beat + 1'b1;
                    if (q.beat == LAST_BEAT) begin
                        d.wb_pend = 1'b0;
                        d.st      = S_IDLE;
                    end
                end
            end
            S_UNC: begin
                mem_valid = 1'b1;
                mem_write = q.wr;
                mem_addr  = q.addr;
                mem_be    = lane_be;
                mem_wdata = q.wdata;
                if (mem_ready) begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = mem_rdata;
                    d.st    = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
endmodule

// File: rtl/wbls_checker.sv
module wbls_checker
    import wbls_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be,
    input seq_st_t           st,
    input logic              fetch,
    input logic              cached
);
    AST_TAKEN_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid); // R11

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

    AST_FILL_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FILL && $past(st) != S_FILL) |-> (mem_addr[3:2] == 2'd0 && !mem_write && mem_be == 4'hF)); // R1

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FILL && mem_ready && mem_addr[3:2] != 2'd3)
        |=> (st == S_FILL && mem_addr[3:2] == $past(mem_addr[3:2]) + 2'd1)); // R1

    AST_WB_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WBACK && $past(st) != S_WBACK) |-> $past(st) == S_FILL); // R6

    AST_LOOKUP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOOKUP && cached) |=> !(mem_valid && mem_write)); // R4

    AST_UNC_FETCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_UNC && fetch && mem_valid) |-> mem_be == (mem_addr[1] ? 4'hC : 4'hF)); // R8
endmodule

bind wb_line_seq wbls_checker #(.ADDR_W(ADDR_W)) u_wbls_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .st        (q.st),
    .fetch     (q.fetch),
    .cached    (q.cached)
);

// File: tb/wb_line_seq_bench.sv
module wb_line_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cached = 1'b0, req_fetch = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mem_valid, mem_ready, mem_write;
    logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [11:0] mem_addr;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;

    logic [31:0] bmem [1024];
    logic [31:0] view [1024];
    logic [5:0]  mtag [4];
    logic        mval [4];
    logic        mdirty [4];

    int          log_n = 0;
    logic [11:0] lg_addr [16];
    logic        lg_wr [16];
    logic [3:0]  lg_be [16];
    logic [31:0] lg_wdata [16];

    logic        stall_en = 1'b0;
    logic [1:0]  stall_cnt = 2'd0;

    always #2.5 clk = ~clk;

    assign mem_ready = !stall_en || (stall_cnt != 2'd0);
    assign mem_rdata = bmem[mem_addr[11:2]];

    wb_line_seq #(.ADDR_W(12), .SETS(4)) u_wb_line_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_cached(req_cached), .req_fetch(req_fetch), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i] <= {16'(i) ^ 16'hBEEF, 16'(i * 7)};
        end
    end

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 2'd1;
        if (rst_n && mem_valid && mem_ready) begin
            if (log_n < 16) begin
                lg_addr[log_n]  = mem_addr;
                lg_wr[log_n]    = mem_write;
                lg_be[log_n]    = mem_be;
                lg_wdata[log_n] = mem_wdata;
            end
            log_n = log_n + 1;
            if (mem_write) begin
                for (int b = 0; b < 4; b++) begin
                    if (mem_be[b]) bmem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                end
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic f, input logic [1:0] sz, input logic [1:0] lo);
        if (f) return lo[1] ? 4'hC : 4'hF;
        case (sz)
            2'd0:    return 4'b0001 << lo;
            2'd1:    return lo[1] ? 4'hC : 4'h3;
            default: return 4'hF;
        endcase
    endfunction

    task automatic access(input logic w, input logic c, input logic f, input logic [1:0] sz,
                          input logic [11:0] a, input logic [31:0] wd);
        int idx, nrd, nwr, lat, waited, exp_lat;
        logic [11:0] base, vbase;
        logic [3:0]  be;
        logic [31:0] got;
        bit          hit, wbk;
        string       rq;
        idx   = int'(a[5:4]);
        base  = {a[11:4], 4'h0};
        vbase = {mtag[idx], a[5:4], 4'h0};
        hit   = c && mval[idx] && (mtag[idx] == a[11:6]);
        wbk   = c && !hit && mval[idx] && mdirty[idx];
        be    = exp_be(f, sz, a[1:0]);
        nrd   = !c ? (w ? 0 : 1) : (hit ? 0 : 4);
        nwr   = !c ? (w ? 1 : 0) : (wbk ? 4 : 0);
        if (!c)       rq = f ? "R8" : (w ? "R7" : "R9");
        else if (hit) rq = w ? "R4" : "R3";
        else if (wbk) rq = "R6";
        else          rq = w ? "R5" : "R2";
        exp_lat = !c ? 3 : (hit ? 2 : 6);

        @(negedge clk);
        log_n = 0;
        req_write = w; req_cached = c; req_fetch = f; req_size = sz;
        req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        got = rsp_rdata;
        chk(rsp_valid == 1'b1, "R10", 32'(rsp_valid), 32'd1);
        if (!stall_en) chk(lat == exp_lat, rq, 32'(lat), 32'(exp_lat));
        if (!w) chk(got == view[a[11:2]], rq, got, view[a[11:2]]);
        waited = 0;
        while (!req_ready && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(log_n == nrd + nwr, "R10", 32'(log_n), 32'(nrd + nwr));
        chk(log_n == nrd + nwr, rq, 32'(log_n), 32'(nrd + nwr));
        if (c && !hit) begin
            for (int i = 0; i < 4; i++) begin
                chk(!lg_wr[i] && lg_be[i] == 4'hF && lg_addr[i] == base + 12'(4 * i),
                    "R1", {lg_wr[i], lg_be[i], lg_addr[i]}, {1'b0, 4'hF, base + 12'(4 * i)});
            end
        end
        if (wbk) begin
            for (int i = 0; i < 4; i++) begin
                chk(lg_wr[4+i] && lg_addr[4+i] == vbase + 12'(4 * i), "R6",
                    {lg_wr[4+i], lg_addr[4+i]}, {1'b1, vbase + 12'(4 * i)});
                chk(lg_wdata[4+i] == view[vbase[11:2] + 10'(i)], "R6",
                    lg_wdata[4+i], view[vbase[11:2] + 10'(i)]);
            end
        end
        if (!c) begin
            chk(lg_addr[0] == a && lg_wr[0] == w && lg_be[0] == be, rq,
                {lg_wr[0], lg_be[0], lg_addr[0]}, {w, be, a});
            if (w) chk(lg_wdata[0] == wd, rq, lg_wdata[0], wd);
        end
        if (c) begin
            mdirty[idx] = hit ? (mdirty[idx] | w) : w;
            mval[idx]   = 1'b1;
            mtag[idx]   = a[11:6];
        end
        if (w) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) view[a[11:2]][b*8 +: 8] = wd[b*8 +: 8];
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) view[i] = {16'(i) ^ 16'hBEEF, 16'(i * 7)};
        for (int s = 0; s < 4; s++) begin
            mval[s] = 1'b0; mdirty[s] = 1'b0; mtag[s] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", 32'(req_ready), 32'd1);
        chk(mem_valid == 1'b0, "R11", 32'(mem_valid), 32'd0);
        chk(rsp_valid == 1'b0, "R11", 32'(rsp_valid), 32'd0);

        // R2: misses of every width, including a fetch at 4n+2
        access(0, 1, 0, 2'd0, 12'(64 + 0 * 16 + 5), 0);
        access(0, 1, 0, 2'd1, 12'(64 + 1 * 16 + 10), 0);
        access(0, 1, 0, 2'd2, 12'(64 + 2 * 16 + 12), 0);
        access(0, 1, 1, 2'd1, 12'(64 + 3 * 16 + 6), 0);

        // R3: hits on every word of every set
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) begin
                access(0, 1, 0, 2'd2, 12'(64 + s * 16 + w * 4), 0);
                access(0, 1, 1, 2'd1, 12'(64 + s * 16 + w * 4 + 2), 0);
            end
        end

        // R4: write hits at every byte offset, half-words, then read back
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 16; o++) begin
                access(1, 1, 0, 2'd0, 12'(64 + s * 16 + o), 32'h11223344 * (o + 1));
            end
        end
        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 16; o += 2) begin
                access(1, 1, 0, 2'd1, 12'(64 + s * 16 + o), 32'hA5C30F69 ^ (o << 12));
            end
        end
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) access(0, 1, 0, 2'd2, 12'(64 + s * 16 + w * 4), 0);
        end

        // R5 and R6: write misses over dirty victims, then read back the merge
        access(1, 1, 0, 2'd0, 12'(128 + 0 * 16 + 3), 32'hDEADBEEF);
        access(1, 1, 0, 2'd1, 12'(128 + 1 * 16 + 6), 32'hCAFEF00D);
        access(1, 1, 0, 2'd2, 12'(128 + 2 * 16 + 8), 32'h0BADC0DE);
        access(1, 1, 0, 2'd0, 12'(128 + 3 * 16 + 13), 32'h76543210);
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) access(0, 1, 0, 2'd2, 12'(128 + s * 16 + w * 4), 0);
        end

        // R6: dirty victim on a read miss, then clean victims skip write-back
        for (int s = 0; s < 4; s++) begin
            access(0, 1, 0, 2'd2, 12'(192 + s * 16 + 4), 0);
            access(0, 1, 0, 2'd2, 12'(64 + s * 16), 0);
            access(0, 1, 0, 2'd2, 12'(128 + s * 16 + 8), 0);
        end

        // R7, R9: uncached data accesses of every width and offset
        for (int o = 0; o < 4; o++) access(1, 0, 0, 2'd0, 12'(12'h800 + o), 32'h01020304 << o);
        access(1, 0, 0, 2'd1, 12'h810, 32'h13579BDF);
        access(1, 0, 0, 2'd1, 12'h812, 32'h2468ACE0);
        access(1, 0, 0, 2'd2, 12'h820, 32'hF0E1D2C3);
        for (int o = 0; o < 4; o++) access(0, 0, 0, 2'd0, 12'(12'h800 + o), 0);
        access(0, 0, 0, 2'd1, 12'h810, 0);
        access(0, 0, 0, 2'd1, 12'h812, 0);
        access(0, 0, 0, 2'd2, 12'h820, 0);

        // R8: uncached fetches alternate between 4n and 4n+2
        for (int k = 0; k < 8; k++) access(0, 0, 1, 2'd0, 12'(12'h900 + 2 * k), 0);

        // R1 under memory stalls, with dirty write-backs
        stall_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            access(1, 1, 0, 2'd2, 12'(64 + s * 16 + 8), 32'h5555AAAA + 32'(s));
            access(1, 1, 0, 2'd2, 12'(192 + s * 16 + 4), 32'h3333CCCC + 32'(s));
            access(0, 1, 0, 2'd2, 12'(64 + s * 16 + 8), 0);
        end
        stall_en = 1'b0;

        summary();
        $finish;
    end
endmodule